// File: doc/BRIEF.md
# Multi-Function GPIO Pin Bank

A bank of general-purpose pins in which every pin has a 6-bit function code. The code either routes one of several on-chip signals onto the pin or turns the pin into a plain logic output or input. The on-chip signals are two interrupt lines, four clock outputs and two PWM outputs, and they come into the block as ports. In plain output mode a per-pin level bit drives the pad, and a polarity bit can invert it. In plain input mode the pad passes through a two-flop synchroniser and an optional debounce filter. The debounce counts pulses of a shared tick enable.

The filtered level is visible at all times on a readback port. A change of that level in either direction sets a sticky status bit. Software clears the bit by writing 1 to it. A per-pin mask decides whether the bit takes part in a single combined interrupt request. Each pin is configured by a write strobe with a pin index. The level bit has its own write strobe.

Top module: `gpio_pin_bank`

## Requirements
- R1: After reset every pin has function 01h with direction 1 (input), polarity 0, debounce off, debounce length 4, mask 0 and level bit 0. With these settings every `pin_oe` is 0, `pin_out` is 0, every `sts` bit is 0 and `irq_req` is 0.
- R2: With function 01h and direction 0, the pin sets `pin_oe` to 1 and drives `pin_out` = level XOR polarity. A level write (`lvl_we` with `lvl_idx`) changes `pin_out` in the cycle after the write edge.
- R3: With function 01h and direction 1, `pin_oe` is 0. With debounce off, `lvl_rd` equals `pin_in` delayed by three clocks, and the polarity bit has no effect on `lvl_rd`.
- R4: Function 02h drives `src_irq1` and 03h drives `src_irq2`. Function 08h drives `src_pwm1` and 09h drives `src_pwm2`. For all four, `pin_oe` is 1 and the signal is not inverted.
- R5: Function 04h drives `src_sysclk`, 05h drives `src_loop1_clk`, 06h drives `src_loop2_clk` and 3Dh drives `src_async_clk`, each with `pin_oe` 1 and without inversion.
- R6: Any other function code, 00h and 07h included, gives `pin_oe` 0 and `pin_out` 0.
- R7: With debounce on, the filtered level takes a new value only on the N-th clock edge at which `tick_en` is high while the synchronised pad differs from the filtered level, where N is the debounce length (0 acts as 1). A difference that ends earlier resets the count, and the level does not change while `tick_en` is low.
- R8: Every rising or falling change of the filtered level sets that pin's `sts` bit one clock after `lvl_rd` changes.
- R9: `sts` is sticky. A 1 on `sts_clr` clears the bit at the next edge, unless a level change sets it at that same edge, in which case the bit stays 1.
- R10: `irq_req` is 1 exactly when some pin has both its `sts` bit and its mask bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Debounce time-base enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Pin addressed by a configuration write |
| cfg_fn | input | 6 | Function code |
| cfg_dir | input | 1 | Direction, 1 = input |
| cfg_pol | input | 1 | Output polarity invert |
| cfg_db_en | input | 1 | Debounce enable |
| cfg_db_len | input | DB_W | Debounce length in ticks |
| cfg_mask | input | 1 | Interrupt mask, 1 = enabled |
| lvl_we | input | 1 | Level bit write strobe |
| lvl_idx | input | IDX_W | Pin addressed by a level write |
| lvl_wdata | input | 1 | Level bit value |
| sts_clr | input | NUM_PINS | Write-1-to-clear for status bits |
| src_irq1 | input | 1 | Interrupt line 1 |
| src_irq2 | input | 1 | Interrupt line 2 |
| src_sysclk | input | 1 | Clock derived from system clock |
| src_loop1_clk | input | 1 | First frequency-locked loop clock |
| src_loop2_clk | input | 1 | Second frequency-locked loop clock |
| src_pwm1 | input | 1 | PWM output 1 |
| src_pwm2 | input | 1 | PWM output 2 |
| src_async_clk | input | 1 | Clock derived from asynchronous clock |
| pin_in | input | NUM_PINS | Pad input levels |
| pin_out | output | NUM_PINS | Pad output levels |
| pin_oe | output | NUM_PINS | Pad output enables |
| lvl_rd | output | NUM_PINS | Filtered pad level readback |
| sts | output | NUM_PINS | Sticky edge status |
| irq_req | output | 1 | Combined masked interrupt request |

## Verification
The properties check the following on every cycle: a filtered-level change always sets its status bit; a status bit holds until it is cleared; a clear without a coinciding change empties the bit; and the debounced level stays still on cycles without a tick. Other behaviour can only be shown by the bench scenarios. These include the exact three-clock input latency, the debounce rejecting glitches shorter than the programmed length, the full function-code decode including unlisted codes, polarity having no effect on readback, and the priority of an edge over a clear that falls in the same cycle. The bench shows these by comparing every output against a behavioural model on every clock.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

  typedef enum logic [5:0] {
    FN_OFF     = 6'h00,
    FN_GPIO    = 6'h01,
    FN_IRQA    = 6'h02,
    FN_IRQB    = 6'h03,
    FN_SYSCK   = 6'h04,
    FN_LOOP1CK = 6'h05,
    FN_LOOP2CK = 6'h06,
    FN_PWMA    = 6'h08,
    FN_PWMB    = 6'h09,
    FN_ASYNCCK = 6'h3D
  } fn_code_e;

  typedef struct packed {
    logic irq1;
    logic irq2;
    logic sysck;
    logic loop1ck;
    logic loop2ck;
    logic pwm1;
    logic pwm2;
    logic asyncck;
  } src_bus_t;

  typedef struct packed {
    logic [5:0] fn;
    logic       dir;
    logic       pol;
    logic       db_en;
    logic       mask;
  } pin_cfg_t;

endpackage

// File: rtl/gpb_in_filter.sv
module gpb_in_filter #(
  parameter int DB_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_en,
  input  logic            db_en,
  input  logic [DB_W-1:0] db_len,
  input  logic            pad_i,
  output logic            lvl_o
);

  logic            s1_q, s1_d;
  logic            s2_q, s2_d;
  logic            stab_q, stab_d;
  logic [DB_W-1:0] cnt_q, cnt_d;
  logic [DB_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + (DB_W+1)'(1);

  always_comb begin
    s1_d   = pad_i;
    s2_d   = s1_q;
    stab_d = stab_q;
    cnt_d  = cnt_q;
    if (!db_en) begin
      stab_d = s2_q;
      cnt_d  = '0;
    end else if (s2_q == stab_q) begin
      cnt_d = '0;
    end else if (tick_en) begin
      if (cnt_inc >= {1'b0, db_len}) begin
        stab_d = s2_q;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_inc[DB_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      stab_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      s1_q   <= s1_d;
      s2_q   <= s2_d;
      stab_q <= stab_d;
      cnt_q  <= cnt_d;
    end
  end

  assign lvl_o = stab_q;

  // R7: with debounce on, no tick means the filtered level holds
  p_db_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (db_en && !tick_en) |=> $stable(lvl_o));

endmodule

// File: rtl/gpb_edge_flag.sv
module gpb_edge_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic clr_i,
  output logic sts_o
);

  logic prev_q;
  logic sts_q, sts_d;
  logic chg;

  assign chg = lvl_i ^ prev_q;

  always_comb begin
    sts_d = sts_q;
    if (clr_i) sts_d = 1'b0;
    if (chg)   sts_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      sts_q  <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      sts_q  <= sts_d;
    end
  end

  assign sts_o = sts_q;

  // R8: a change of the filtered level always latches the status bit
  p_edge_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_i != prev_q) |=> sts_o);

  // R9: status holds while no clear is applied
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_o && !clr_i) |=> sts_o);

  // R9: a clear without a coinciding change empties the bit
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_o && clr_i && (lvl_i == prev_q)) |=> !sts_o);

endmodule

// File: rtl/gpb_drive_sel.sv
module gpb_drive_sel
  import gpb_pkg::*;
(
  input  logic [5:0] fn_i,
  input  logic       dir_i,
  input  logic       pol_i,
  input  logic       lvl_i,
  input  src_bus_t   src_i,
  output logic       out_o,
  output logic       oe_o
);

  always_comb begin
    oe_o  = 1'b1;
    out_o = 1'b0;
    case (fn_i)
      FN_GPIO: begin
        oe_o  = !dir_i;
        out_o = dir_i ? 1'b0 : (lvl_i ^ pol_i);
      end
      FN_IRQA:    out_o = src_i.irq1;
      FN_IRQB:    out_o = src_i.irq2;
      FN_SYSCK:   out_o = src_i.sysck;
      FN_LOOP1CK: out_o = src_i.loop1ck;
      FN_LOOP2CK: out_o = src_i.loop2ck;
      FN_PWMA:    out_o = src_i.pwm1;
      FN_PWMB:    out_o = src_i.pwm2;
      FN_ASYNCCK: out_o = src_i.asyncck;
      default: begin
        oe_o  = 1'b0;
        out_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank
  import gpb_pkg::*;
#(
  parameter int NUM_PINS   = 4,
  parameter int DB_W       = 4,
  parameter int DB_DEFAULT = 4,
  localparam int IDX_W     = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_en,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic [5:0]          cfg_fn,
  input  logic                cfg_dir,
  input  logic                cfg_pol,
  input  logic                cfg_db_en,
  input  logic [DB_W-1:0]     cfg_db_len,
  input  logic                cfg_mask,
  input  logic                lvl_we,
  input  logic [IDX_W-1:0]    lvl_idx,
  input  logic                lvl_wdata,
  input  logic [NUM_PINS-1:0] sts_clr,
  input  logic                src_irq1,
  input  logic                src_irq2,
  input  logic                src_sysclk,
  input  logic                src_loop1_clk,
  input  logic                src_loop2_clk,
  input  logic                src_pwm1,
  input  logic                src_pwm2,
  input  logic                src_async_clk,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] lvl_rd,
  output logic [NUM_PINS-1:0] sts,
  output logic                irq_req
);

  localparam pin_cfg_t CFG_RST = '{fn: FN_GPIO, dir: 1'b1, pol: 1'b0,
                                   db_en: 1'b0, mask: 1'b0};

  src_bus_t            src;
  logic [NUM_PINS-1:0] mask_vec;

  assign src = '{irq1: src_irq1, irq2: src_irq2, sysck: src_sysclk,
                 loop1ck: src_loop1_clk, loop2ck: src_loop2_clk,
                 pwm1: src_pwm1, pwm2: src_pwm2, asyncck: src_async_clk};

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    pin_cfg_t        cfg_q, cfg_d;
    logic [DB_W-1:0] len_q, len_d;
    logic            lvl_q, lvl_d;
    logic            cfg_hit, lvl_hit;

    assign cfg_hit = cfg_we && (cfg_idx == IDX_W'(i));
    assign lvl_hit = lvl_we && (lvl_idx == IDX_W'(i));

    always_comb begin
      cfg_d = cfg_q;
      len_d = len_q;
      lvl_d = lvl_q;
      if (cfg_hit) begin
        cfg_d = '{fn: cfg_fn, dir: cfg_dir, pol: cfg_pol,
                  db_en: cfg_db_en, mask: cfg_mask};
        len_d = cfg_db_len;
      end
      if (lvl_hit) lvl_d = lvl_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q <= CFG_RST;
        len_q <= DB_W'(DB_DEFAULT);
        lvl_q <= 1'b0;
      end else begin
        cfg_q <= cfg_d;
        len_q <= len_d;
        lvl_q <= lvl_d;
      end
    end

    gpb_in_filter #(.DB_W(DB_W)) i_filt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .db_en   (cfg_q.db_en),
      .db_len  (len_q),
      .pad_i   (pin_in[i]),
      .lvl_o   (lvl_rd[i])
    );

    gpb_edge_flag i_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (lvl_rd[i]),
      .clr_i (sts_clr[i]),
      .sts_o (sts[i])
    );

    gpb_drive_sel i_drv (
      .fn_i  (cfg_q.fn),
      .dir_i (cfg_q.dir),
      .pol_i (cfg_q.pol),
      .lvl_i (lvl_q),
      .src_i (src),
      .out_o (pin_out[i]),
      .oe_o  (pin_oe[i])
    );

    assign mask_vec[i] = cfg_q.mask;
  end

  assign irq_req = |(sts & mask_vec);

endmodule

// File: tb/test_gpio_pin_bank.sv
`timescale 1ns/1ps
module test_gpio_pin_bank;
  localparam int N = 4;
  localparam int DBW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic tick_gate = 1'b0;
  logic cfg_we = 0, cfg_dir = 0, cfg_pol = 0, cfg_db_en = 0, cfg_mask = 0;
  logic [1:0] cfg_idx = 0, lvl_idx = 0;
  logic [5:0] cfg_fn = 0;
  logic [DBW-1:0] cfg_db_len = 0;
  logic lvl_we = 0, lvl_wdata = 0;
  logic [N-1:0] sts_clr = 0, pin_in = 0;
  logic [N-1:0] pin_out, pin_oe, lvl_rd, sts;
  logic irq_req;
  logic [7:0] free_cnt = 0;
  logic tick_en;

  assign tick_en = tick_gate && (free_cnt[1:0] == 2'b00);

  always @(posedge clk) begin
    #1;
    free_cnt = free_cnt + 8'd1;
  end

  gpio_pin_bank #(.NUM_PINS(N), .DB_W(DBW), .DB_DEFAULT(4)) i_gpio_pin_bank (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_fn(cfg_fn), .cfg_dir(cfg_dir),
    .cfg_pol(cfg_pol), .cfg_db_en(cfg_db_en), .cfg_db_len(cfg_db_len),
    .cfg_mask(cfg_mask), .lvl_we(lvl_we), .lvl_idx(lvl_idx),
    .lvl_wdata(lvl_wdata), .sts_clr(sts_clr),
    .src_irq1(free_cnt[1]), .src_irq2(free_cnt[2]), .src_sysclk(free_cnt[0]),
    .src_loop1_clk(free_cnt[3]), .src_loop2_clk(free_cnt[4]),
    .src_pwm1(free_cnt[5]), .src_pwm2(free_cnt[6]), .src_async_clk(free_cnt[7]),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .lvl_rd(lvl_rd),
    .sts(sts), .irq_req(irq_req));

  // behavioural model state
  int m_fn[N], m_dir[N], m_pol[N], m_dben[N], m_len[N], m_mask[N], m_lvl[N];
  int m_pipe[N][$];
  int m_filt[N], m_prev[N], m_run[N], m_sts[N];

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit cmp_on = 0, done = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_fn[i] = 1; m_dir[i] = 1; m_pol[i] = 0; m_dben[i] = 0;
        m_len[i] = 4; m_mask[i] = 0; m_lvl[i] = 0;
        m_pipe[i] = '{0, 0};
        m_filt[i] = 0; m_prev[i] = 0; m_run[i] = 0; m_sts[i] = 0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        int synced, nf, nr, need;
        synced = m_pipe[i][0];
        nf = m_filt[i];
        nr = m_run[i];
        need = (m_len[i] == 0) ? 1 : m_len[i];
        if (m_dben[i] == 0) begin
          nf = synced; nr = 0;
        end else if (synced == m_filt[i]) begin
          nr = 0;
        end else if (tick_en) begin
          nr = nr + 1;
          if (nr >= need) begin nf = synced; nr = 0; end
        end
        if (m_filt[i] != m_prev[i]) m_sts[i] = 1;
        else if (sts_clr[i]) m_sts[i] = 0;
        m_prev[i] = m_filt[i];
        m_filt[i] = nf;
        m_run[i] = nr;
        void'(m_pipe[i].pop_front());
        m_pipe[i].push_back(int'(pin_in[i]));
        if (cfg_we && cfg_idx == i) begin
          m_fn[i] = cfg_fn; m_dir[i] = cfg_dir; m_pol[i] = cfg_pol;
          m_dben[i] = cfg_db_en; m_len[i] = cfg_db_len; m_mask[i] = cfg_mask;
        end
        if (lvl_we && lvl_idx == i) m_lvl[i] = lvl_wdata;
      end
    end
  end

  task automatic chk(string req, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", req, what, act, expv, $time);
    end
  endtask

  function automatic int exp_src(int fn);
    case (fn)
      2: return free_cnt[1];
      3: return free_cnt[2];
      4: return free_cnt[0];
      5: return free_cnt[3];
      6: return free_cnt[4];
      8: return free_cnt[5];
      9: return free_cnt[6];
      61: return free_cnt[7];
      default: return -1;
    endcase
  endfunction

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      int any;
      any = 0;
      for (int i = 0; i < N; i++) begin
        int eo, eoe, s;
        s = exp_src(m_fn[i]);
        if (m_fn[i] == 1) begin
          eoe = (m_dir[i] == 0);
          eo = eoe ? (m_lvl[i] ^ m_pol[i]) : 0;
        end else if (s >= 0) begin
          eoe = 1; eo = s;
        end else begin
          eoe = 0; eo = 0;
        end
        chk(cur_req, $sformatf("pin%0d oe", i), int'(pin_oe[i]), eoe);
        chk(cur_req, $sformatf("pin%0d out", i), int'(pin_out[i]), eo);
        chk(cur_req, $sformatf("pin%0d lvl_rd", i), int'(lvl_rd[i]), m_filt[i]);
        chk(cur_req, $sformatf("pin%0d sts", i), int'(sts[i]), m_sts[i]);
        if (m_sts[i] && m_mask[i]) any = 1;
      end
      chk(cur_req, "irq_req", int'(irq_req), any);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_cfg(int idx, int fn, int dir, int pol, int dben, int len, int mask);
    cfg_we = 1; cfg_idx = idx[1:0]; cfg_fn = fn[5:0]; cfg_dir = dir[0];
    cfg_pol = pol[0]; cfg_db_en = dben[0]; cfg_db_len = len[DBW-1:0]; cfg_mask = mask[0];
    step(1);
    cfg_we = 0;
  endtask

  task automatic wr_lvl(int idx, int v);
    lvl_we = 1; lvl_idx = idx[1:0]; lvl_wdata = v[0];
    step(1);
    lvl_we = 0;
  endtask

  task automatic clr(int idx);
    sts_clr[idx] = 1'b1;
    step(1);
    sts_clr[idx] = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    cmp_on = 1;
    rst_n = 1;
    // R1 reset state, directed
    @(negedge clk);
    chk("R1", "oe", int'(pin_oe), 0);
    chk("R1", "sts", int'(sts), 0);
    chk("R1", "irq", int'(irq_req), 0);
    step(4);

    // R2 plain output with and without polarity
    cur_req = "R2";
    wr_cfg(0, 1, 0, 0, 0, 4, 0);
    wr_lvl(0, 1);
    @(negedge clk);
    chk("R2", "pin0 out lvl1 pol0", int'(pin_out[0]), 1);
    step(1);
    wr_cfg(0, 1, 0, 1, 0, 4, 0);
    @(negedge clk);
    chk("R2", "pin0 out lvl1 pol1", int'(pin_out[0]), 0);
    step(1);
    wr_lvl(0, 0);
    step(3);

    // R4 and R5 routed sources on pin 1
    cur_req = "R4";
    wr_cfg(1, 2, 0, 1, 0, 4, 0); step(20);
    wr_cfg(1, 3, 0, 0, 0, 4, 0); step(20);
    wr_cfg(1, 8, 0, 1, 0, 4, 0); step(70);
    wr_cfg(1, 9, 0, 0, 0, 4, 0); step(130);
    cur_req = "R5";
    wr_cfg(1, 4, 0, 1, 0, 4, 0); step(10);
    wr_cfg(1, 5, 0, 0, 0, 4, 0); step(20);
    wr_cfg(1, 6, 0, 0, 0, 4, 0); step(40);
    wr_cfg(1, 61, 0, 1, 0, 4, 0); step(260);

    // R6 unlisted codes
    cur_req = "R6";
    wr_cfg(1, 0, 0, 0, 0, 4, 0);
    @(negedge clk);
    chk("R6", "code 00h oe", int'(pin_oe[1]), 0);
    step(5);
    wr_cfg(1, 7, 0, 1, 0, 4, 0); step(5);
    wr_cfg(1, 63, 0, 0, 0, 4, 0); step(5);
    wr_cfg(1, 1, 1, 0, 0, 4, 0); step(3);

    // R3 input latency, polarity ignored on readback
    cur_req = "R3";
    wr_cfg(2, 1, 1, 1, 0, 4, 1);
    step(2);
    pin_in[2] = 1'b1;
    step(2);
    @(negedge clk);
    chk("R3", "lvl_rd after 2 clocks", int'(lvl_rd[2]), 0);
    step(1);
    @(negedge clk);
    chk("R3", "lvl_rd after 3 clocks, pol=1", int'(lvl_rd[2]), 1);
    chk("R3", "input pin oe", int'(pin_oe[2]), 0);
    // R8 status one clock later, R10 mask on
    cur_req = "R8";
    step(1);
    @(negedge clk);
    chk("R8", "sts after rising", int'(sts[2]), 1);
    chk("R10", "irq masked-in", int'(irq_req), 1);
    step(1);
    cur_req = "R9";
    clr(2);
    @(negedge clk);
    chk("R9", "sts cleared", int'(sts[2]), 0);
    chk("R10", "irq after clear", int'(irq_req), 0);
    step(2);
    // falling edge with clear coinciding with the setting edge
    cur_req = "R9";
    pin_in[2] = 1'b0;
    step(3);
    sts_clr[2] = 1'b1;
    step(1);
    sts_clr[2] = 1'b0;
    @(negedge clk);
    chk("R9", "edge wins over clear", int'(sts[2]), 1);
    chk("R8", "falling edge level", int'(lvl_rd[2]), 0);
    step(2);
    clr(2);
    // R10 mask off: status set but no request
    cur_req = "R10";
    wr_cfg(2, 1, 1, 0, 0, 4, 0);
    pin_in[2] = 1'b1;
    step(6);
    @(negedge clk);
    chk("R10", "masked-out sts", int'(sts[2]), 1);
    chk("R10", "masked-out irq", int'(irq_req), 0);
    step(1);
    clr(2);

    // R7 debounce on pin 3, length 4 and length 0
    cur_req = "R7";
    tick_gate = 1'b1;
    wr_cfg(3, 1, 1, 0, 1, 4, 1);
    step(4);
    pin_in[3] = 1'b1; step(9); pin_in[3] = 1'b0;   // short glitch
    step(30);
    @(negedge clk);
    chk("R7", "glitch rejected", int'(lvl_rd[3]), 0);
    step(1);
    pin_in[3] = 1'b1;
    step(30);
    @(negedge clk);
    chk("R7", "held level accepted", int'(lvl_rd[3]), 1);
    step(1);
    tick_gate = 1'b0;
    pin_in[3] = 1'b0;
    step(40);
    @(negedge clk);
    chk("R7", "no tick no change", int'(lvl_rd[3]), 1);
    step(1);
    tick_gate = 1'b1;
    step(30);
    wr_cfg(3, 1, 1, 0, 1, 0, 1);
    pin_in[3] = 1'b1; step(20);
    pin_in[3] = 1'b0; step(20);
    wr_cfg(3, 1, 1, 0, 1, 15, 1);
    pin_in[3] = 1'b1; step(80);
    pin_in[3] = 1'b0; step(3); pin_in[3] = 1'b1; step(100);
    clr(3);
    // mixed pattern on all inputs
    cur_req = "R8";
    for (int k = 0; k < 60; k++) begin
      pin_in = pin_in ^ N'(k * 5 + 3);
      step(1 + (k % 7));
    end
    step(50);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule